// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block lays a 64x64 two-plane cursor over a stream of 32-bit pixels. Software programs a bitmap base address, a screen position, a hotspot shift, two colours, an enable bit and a lock bit through a small write-only register port. At the start of each scanline the block checks whether the line falls inside the cursor's vertical span. If it does, the block reads that row's 16 bytes from a synchronous byte-wide memory port: 8 bytes of AND plane followed by 8 bytes of XOR plane. Each incoming pixel is then passed through unchanged, replaced by a cursor colour, or bit-inverted, one cycle later.

Position, base and hotspot writes go into shadow registers. They reach the displayed cursor only on a frame-start pulse, and only while the lock bit is clear. Colours and the enable bit take effect at once.

The row fetch runs as a four-state machine. IDLE means no row is held. FETCH issues 16 consecutive byte reads. DRAIN captures the last returned byte. READY means the row is held and overlay is active. There are four transitions:

- A `line_start` on a line inside the cursor's span, with the cursor enabled, moves any state to FETCH.
- A `line_start` on any other line moves any state to IDLE.
- FETCH moves to DRAIN once the sixteenth read has been issued.
- DRAIN moves to READY on the next cycle.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held and on the first cycle after it, `pix_out_valid` and `mem_rd_en` are 0 and `pix_out` is 0.
- R2: On `line_start` for a line L with the cursor enabled and Y <= L <= Y+63, the block reads 16 consecutive bytes, one per cycle, starting in the cycle after `line_start`. The first address is S + 16*(L-Y), where S = base - hx - 16*hy, taken modulo 2^ADDR_W.
- R3: Let p = pix_x - X be the pixel index within the row, with 0 <= p < 64. Its AND bit is bit 7-(p mod 8) of row byte p/8, and its XOR bit is the same bit of row byte 8+p/8. AND=1 with XOR=1 outputs the bitwise complement of `pix_in`. AND=1 with XOR=0 outputs `pix_in` unchanged.
- R4: With AND=0, the output is colour1 when XOR=1 and colour0 otherwise, in bits 23:0, with bits 31:24 forced to 0xFF.
- R5: With the cursor disabled (register 5 bit 0 clear), on lines outside the span, or for pixels outside X..X+63, the output equals `pix_in` and no memory read is issued for the line.
- R6: A pixel with `pix_x >= active_width` is never modified. Cursor pixels do not carry over to the next line.
- R7: Writes to base, position and hotspot take effect only at a `frame_start` pulse, and only when the lock (bit 31 of the last base write) is clear. A frame start while locked keeps the previous displayed values.
- R8: `pix_out_valid` follows `pix_valid` exactly one cycle later, and `pix_out` belongs to the pixel given in that earlier cycle.
- R9: Register select codes are 0 base, 1 position, 2 hotspot, 3 colour0, 4 colour1 and 5 control. Base keeps bits ADDR_W-1:4, with bit 31 as the lock. Position keeps X from bits 29:16 and Y from bits 11:0. Hotspot keeps hx from bits 21:16 and hy from bits 5:0. Colours keep bits 23:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame start pulse; applies shadow registers if unlocked |
| line_start | input | 1 | Scanline start pulse |
| line_y | input | COORD_W | Number of the line being started |
| active_width | input | COORD_W | Visible pixels per line |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | COORD_W | Column of the input pixel |
| pix_in | input | 32 | Underlying pixel |
| pix_out | output | 32 | Overlaid pixel |
| pix_out_valid | output | 1 | Output pixel valid |
| mem_rd_en | output | 1 | Cursor memory read enable |
| mem_addr | output | ADDR_W | Cursor memory byte address |
| mem_rd_data | input | 8 | Byte returned one cycle after the read |

## Verification
Each pixel result is due one clock after the edge that samples it. The first memory read is due in the cycle after the `line_start` edge, and the row is usable for pixels sampled from the eighteenth edge after `line_start` onward. The bench model computes the expected outputs at each rising edge from the inputs sampled at that edge and compares them at the following falling edge. Pixels are sent only once the fetch window has closed, so every comparison lands in the cycle the result is due.

// File: rtl/curs_pkg.sv
package curs_pkg;
    localparam int CUR_SIDE    = 64;
    localparam int PLANE_BYTES = CUR_SIDE / 8;
    localparam int ROW_BYTES   = 2 * PLANE_BYTES;

    typedef enum logic [2:0] {
        SEL_BASE = 3'd0,
        SEL_POS  = 3'd1,
        SEL_HOT  = 3'd2,
        SEL_CLR0 = 3'd3,
        SEL_CLR1 = 3'd4,
        SEL_CTRL = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_FETCH,
        F_DRAIN,
        F_READY
    } fetch_st_e;
endpackage

// File: rtl/curs_regs.sv
module curs_regs import curs_pkg::*; #(
    parameter int ADDR_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              frame_start,
    output logic              lock,
    output logic              en,
    output logic [23:0]       clr0,
    output logic [23:0]       clr1,
    output logic [13:0]       pos_x,
    output logic [11:0]       pos_y,
    output logic [ADDR_W-1:0] start_addr
);
    logic [ADDR_W-1:0] sh_base, act_base;
    logic [13:0]       sh_x;
    logic [11:0]       sh_y;
    logic [5:0]        sh_hx, sh_hy, act_hx, act_hy;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_base <= '0; sh_x <= '0; sh_y <= '0; sh_hx <= '0; sh_hy <= '0;
            act_base <= '0; pos_x <= '0; pos_y <= '0; act_hx <= '0; act_hy <= '0;
            lock <= 1'b0; en <= 1'b0; clr0 <= '0; clr1 <= '0;
        end else begin
            if (frame_start && !lock) begin
                act_base <= sh_base;
                pos_x    <= sh_x;
                pos_y    <= sh_y;
                act_hx   <= sh_hx;
                act_hy   <= sh_hy;
            end
            if (reg_we) begin
                unique case (reg_sel)
                    SEL_BASE: begin
                        sh_base <= {reg_wdata[ADDR_W-1:4], 4'b0000};
                        lock    <= reg_wdata[31];
                    end
                    SEL_POS: begin
                        sh_x <= reg_wdata[29:16];
                        sh_y <= reg_wdata[11:0];
                    end
                    SEL_HOT: begin
                        sh_hx <= reg_wdata[21:16];
                        sh_hy <= reg_wdata[5:0];
                    end
                    SEL_CLR0: clr0 <= reg_wdata[23:0];
                    SEL_CLR1: clr1 <= reg_wdata[23:0];
                    SEL_CTRL: en   <= reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        start_addr = act_base - ADDR_W'(act_hx) - ADDR_W'({act_hy, 4'b0000});
    end
endmodule

// File: rtl/curs_fetch.sv
module curs_fetch import curs_pkg::*; #(
    parameter int ADDR_W  = 27,
    parameter int COORD_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   line_start,
    input  logic [COORD_W-1:0]     line_y,
    input  logic                   en,
    input  logic [11:0]            pos_y,
    input  logic [ADDR_W-1:0]      start_addr,
    input  logic [7:0]             mem_rd_data,
    output logic                   mem_rd_en,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   row_ok,
    output logic [ROW_BYTES-1:0][7:0] row_bytes
);
    localparam int CNT_W = $clog2(ROW_BYTES);

    fetch_st_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt, pend_i;
    logic               pend_v;
    logic [ADDR_W-1:0]  row_base;
    logic [COORD_W-1:0] diff;
    logic               hit;

    always_comb begin
        diff = line_y - COORD_W'(pos_y);
        hit  = en && (line_y >= COORD_W'(pos_y)) && (diff < COORD_W'(CUR_SIDE));
    end

    always_comb begin
        state_d = state_q;
        if (line_start) begin
            state_d = hit ? F_FETCH : F_IDLE;
        end else begin
            unique case (state_q)
                F_FETCH: if (cnt == CNT_W'(ROW_BYTES - 1)) state_d = F_DRAIN;
                F_DRAIN: state_d = F_READY;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= F_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0; pend_i <= '0; pend_v <= 1'b0;
            row_base <= '0; row_bytes <= '0;
        end else begin
            if (line_start) begin
                row_base <= start_addr + ADDR_W'({diff[5:0], 4'b0000});
                cnt      <= '0;
            end else if (state_q == F_FETCH) begin
                cnt <= cnt + 1'b1;
            end
            pend_v <= mem_rd_en && !line_start;
            pend_i <= cnt;
            if (pend_v) row_bytes[pend_i] <= mem_rd_data;
        end
    end

    always_comb begin
        mem_rd_en = (state_q == F_FETCH);
        mem_addr  = row_base + ADDR_W'(cnt);
        row_ok    = (state_q == F_READY);
    end
endmodule

// File: rtl/curs_pixel.sv
module curs_pixel import curs_pkg::*; #(
    parameter int COORD_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pix_valid,
    input  logic [COORD_W-1:0]        pix_x,
    input  logic [31:0]               pix_in,
    input  logic [COORD_W-1:0]        active_width,
    input  logic                      row_ok,
    input  logic                      en,
    input  logic [13:0]               cur_x,
    input  logic [ROW_BYTES-1:0][7:0] row_bytes,
    input  logic [23:0]               clr0,
    input  logic [23:0]               clr1,
    output logic [31:0]               pix_out,
    output logic                      pix_out_valid
);
    logic [COORD_W-1:0] off;
    logic [5:0]         p;
    logic               in_win, and_b, xor_b;
    logic [31:0]        result;

    always_comb begin
        off    = pix_x - COORD_W'(cur_x);
        p      = off[5:0];
        in_win = row_ok && en && (pix_x >= COORD_W'(cur_x)) &&
                 (off < COORD_W'(CUR_SIDE)) && (pix_x < active_width);
        and_b  = row_bytes[{1'b0, p[5:3]}][~p[2:0]];
        xor_b  = row_bytes[{1'b1, p[5:3]}][~p[2:0]];
        if (!in_win)     result = pix_in;
        else if (and_b)  result = xor_b ? ~pix_in : pix_in;
        else             result = {8'hFF, xor_b ? clr1 : clr0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out       <= '0;
            pix_out_valid <= 1'b0;
        end else begin
            pix_out_valid <= pix_valid;
            if (pix_valid) pix_out <= result;
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay import curs_pkg::*; #(
    parameter int ADDR_W  = 27,
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [2:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic [COORD_W-1:0] line_y,
    input  logic [COORD_W-1:0] active_width,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [31:0]        pix_in,
    output logic [31:0]        pix_out,
    output logic               pix_out_valid,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [7:0]         mem_rd_data
);
    logic                      cur_lock, cur_en, row_ok;
    logic [23:0]               clr0, clr1;
    logic [13:0]               cur_x;
    logic [11:0]               cur_y;
    logic [ADDR_W-1:0]         start_addr;
    logic [ROW_BYTES-1:0][7:0] row_bytes;

    curs_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .lock(cur_lock),
        .en(cur_en), .clr0(clr0), .clr1(clr1), .pos_x(cur_x), .pos_y(cur_y),
        .start_addr(start_addr)
    );

    curs_fetch #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y),
        .en(cur_en), .pos_y(cur_y), .start_addr(start_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .row_ok(row_ok), .row_bytes(row_bytes)
    );

    curs_pixel #(.COORD_W(COORD_W)) u_pixel (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
        .pix_in(pix_in), .active_width(active_width), .row_ok(row_ok),
        .en(cur_en), .cur_x(cur_x), .row_bytes(row_bytes), .clr0(clr0),
        .clr1(clr1), .pix_out(pix_out), .pix_out_valid(pix_out_valid)
    );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
    parameter int ADDR_W  = 27,
    parameter int COORD_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [31:0]        pix_in,
    input logic [COORD_W-1:0] active_width,
    input logic [31:0]        pix_out,
    input logic               pix_out_valid,
    input logic               mem_rd_en,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               line_start,
    input logic               frame_start,
    input logic               lock,
    input logic               en,
    input logic [13:0]        pos_x,
    input logic [11:0]        pos_y
);
    p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> pix_out_valid);

    p_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !pix_out_valid);

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && !line_start) |=>
        (!mem_rd_en || mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    p_disabled_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !en) |=> (pix_out == $past(pix_in)));

    p_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_x >= active_width) |=> (pix_out == $past(pix_in)));

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && frame_start) |=> ($stable(pos_x) && $stable(pos_y)));
endmodule

bind cursor_overlay cursor_overlay_chk #(.ADDR_W(ADDR_W), .COORD_W(COORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_in(pix_in), .active_width(active_width), .pix_out(pix_out),
    .pix_out_valid(pix_out_valid), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .line_start(line_start), .frame_start(frame_start), .lock(cur_lock),
    .en(cur_en), .pos_x(cur_x), .pos_y(cur_y)
);

// File: tb/cursor_overlay_test.sv
`timescale 1ns/1ps
module cursor_overlay_test;
    localparam int AW = 27;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_sel = '0;
    logic [31:0]   reg_wdata = '0;
    logic          frame_start = 1'b0, line_start = 1'b0;
    logic [CW-1:0] line_y = '0, active_width = 16'd640, pix_x = '0;
    logic          pix_valid = 1'b0;
    logic [31:0]   pix_in = '0;
    logic [31:0]   pix_out;
    logic          pix_out_valid, mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rd_data = '0;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    cursor_overlay uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .frame_start(frame_start), .line_start(line_start),
        .line_y(line_y), .active_width(active_width), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_in(pix_in), .pix_out(pix_out),
        .pix_out_valid(pix_out_valid), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [7:0] memf(input logic [AW-1:0] a);
        return 8'(a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (%s) actual=%h expected=%h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    // reference model state
    logic [AW-1:0] s_base, a_base, row_base;
    int s_x, s_y, s_hx, s_hy, a_x, a_y, a_hx, a_hy;
    bit m_lock, m_en, m_hit;
    logic [23:0] m_c0, m_c1;
    int rc, fl;
    logic [AW-1:0] f_addr;
    bit exp_v, exp_rd;
    logic [31:0] exp_d;
    logic [AW-1:0] exp_addr;
    string exp_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            s_base = '0; a_base = '0; row_base = '0;
            s_x = 0; s_y = 0; s_hx = 0; s_hy = 0; a_x = 0; a_y = 0; a_hx = 0; a_hy = 0;
            m_lock = 0; m_en = 0; m_hit = 0; m_c0 = '0; m_c1 = '0;
            rc = 0; fl = 0; f_addr = '0; exp_v = 0; exp_rd = 0; exp_d = '0; exp_addr = '0;
            exp_tag = "R1";
        end else begin
            int off;
            bit ready;
            ready = (rc == 0) && m_hit;
            // pixel result (R3 R4 R5 R6)
            exp_v = pix_valid;
            off = int'(pix_x) - a_x;
            if (pix_valid) begin
                exp_d = pix_in; exp_tag = "R5";
                if (ready && m_en && off >= 0 && off < 64) begin
                    if (int'(pix_x) >= int'(active_width)) exp_tag = "R6";
                    else begin
                        logic [7:0] ab, xb;
                        bit a, x;
                        ab = memf(row_base + AW'(off / 8));
                        xb = memf(row_base + AW'(8 + off / 8));
                        a = ab[7 - off % 8];
                        x = xb[7 - off % 8];
                        if (a) begin exp_d = x ? ~pix_in : pix_in; exp_tag = "R3"; end
                        else begin exp_d = {8'hFF, x ? m_c1 : m_c0}; exp_tag = "R4"; end
                    end
                end
            end
            // fetch model (R2)
            if (rc > 0) rc--;
            if (fl > 0) begin fl--; f_addr = f_addr + 1'b1; end
            if (line_start) begin
                int ly;
                ly = int'(line_y);
                m_hit = m_en && ly >= a_y && ly < a_y + 64;
                fl = 0; rc = 0;
                if (m_hit) begin
                    logic [AW-1:0] st;
                    st = a_base - AW'(a_hx) - AW'(a_hy * 16);
                    row_base = st + AW'((ly - a_y) * 16);
                    f_addr = row_base; fl = 16; rc = 17;
                end
            end
            exp_rd = fl > 0; exp_addr = f_addr;
            // register model (R7 R9)
            if (frame_start && !m_lock) begin
                a_base = s_base; a_x = s_x; a_y = s_y; a_hx = s_hx; a_hy = s_hy;
            end
            if (reg_we) begin
                case (reg_sel)
                    3'd0: begin s_base = {reg_wdata[AW-1:4], 4'b0}; m_lock = reg_wdata[31]; end
                    3'd1: begin s_x = int'(reg_wdata[29:16]); s_y = int'(reg_wdata[11:0]); end
                    3'd2: begin s_hx = int'(reg_wdata[21:16]); s_hy = int'(reg_wdata[5:0]); end
                    3'd3: m_c0 = reg_wdata[23:0];
                    3'd4: m_c1 = reg_wdata[23:0];
                    3'd5: m_en = reg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pix_out_valid === exp_v, "R8", 32'(pix_out_valid), 32'(exp_v));
            if (exp_v) chk(pix_out === exp_d, exp_tag, pix_out, exp_d);
            chk(mem_rd_en === exp_rd, "R2", 32'(mem_rd_en), 32'(exp_rd));
            if (exp_rd) chk(mem_addr === exp_addr, "R2", 32'(mem_addr), 32'(exp_addr));
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic run_line(input int y, input int n, input bit gaps);
        @(negedge clk); line_start = 1'b1; line_y = CW'(y);
        @(negedge clk); line_start = 1'b0;
        repeat (20) @(negedge clk);
        for (int x = 0; x < n; x++) begin
            if (gaps && (x % 7 == 3)) begin
                pix_valid = 1'b0;
                @(negedge clk);
            end
            pix_valid = 1'b1; pix_x = CW'(x);
            pix_in = 32'h9E3779B9 * 32'(x + 1) + 32'(y * 77);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pix_out_valid === 1'b0, "R1", 32'(pix_out_valid), 0);
        chk(mem_rd_en === 1'b0, "R1", 32'(mem_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pix_out === 32'h0, "R1", pix_out, 0);
        chk(pix_out_valid === 1'b0 && mem_rd_en === 1'b0, "R1", 32'({pix_out_valid, mem_rd_en}), 0);

        phase = "R2 R3 R4 main";
        wr(3'd0, 32'h0001_2340);
        wr(3'd1, 32'h000A_0005);
        wr(3'd2, 32'h0);
        wr(3'd3, 32'h0012_3456);
        wr(3'd4, 32'h80AB_CDEF);
        wr(3'd5, 32'h1);
        frame();
        run_line(5, 90, 0);
        run_line(7, 90, 1);
        run_line(68, 90, 0);
        phase = "R5 outside span";
        run_line(4, 80, 0);
        run_line(69, 80, 0);

        phase = "R6 right edge";
        active_width = 16'd40;
        wr(3'd1, 32'h0014_0005);
        frame();
        run_line(6, 60, 0);
        active_width = 16'd640;

        phase = "R9 field masks";
        wr(3'd2, 32'hFFC3_FFC2);
        wr(3'd1, 32'hC00A_F005);
        frame();
        run_line(9, 80, 1);

        phase = "R7 lock";
        wr(3'd0, 32'h8005_0000);
        wr(3'd1, 32'h0030_0010);
        frame();
        run_line(7, 90, 0);
        run_line(20, 90, 0);
        wr(3'd0, 32'h0005_0000);
        run_line(7, 90, 0);
        frame();
        run_line(20, 120, 0);
        run_line(7, 90, 0);

        phase = "R5 disabled";
        wr(3'd5, 32'h0);
        run_line(20, 120, 0);
        wr(3'd5, 32'h1);
        phase = "R3 R4 origin";
        wr(3'd1, 32'h0000_0000);
        wr(3'd2, 32'h0);
        frame();
        run_line(0, 70, 1);
        run_line(63, 70, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog (%s) actual=running expected=finished", phase);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule